// File: doc/BRIEF.md
# Compare and Mask-Test Condition Unit

This block derives a 2-bit condition code for the compare and bit-test family of integer operations in a CPU pipeline. The datapath supplies an operation selector, two 64-bit operands, a shift count and a width flag. The unit returns the code that a later branch stage consumes. It does not compute shift or insert results itself. It only grades the operands it is given.

The selector covers signed and unsigned two-operand compares, a signed compare against zero, a test of value bits under a mask, an insert-under-mask grading, overflow detection for an arithmetic left shift, and a nonzero check for a leading-one search. The width flag chooses between a full 64-bit view and a 32-bit view of the operands. A single output register holds the code, so the result appears one clock after the inputs are sampled.

Top module: `cmpcc_unit`

## Requirements
- R1: `cc_o` is registered. It reads 0 while `rst` is high. Inputs sampled at a rising edge with `rst` low set `cc_o` at that same edge.
- R2: Selector 0 is a signed compare of `opa_i` against `opb_i`. The code is 0 when they are equal, 1 when `opa_i` is less and 2 when it is greater. It is never 3.
- R3: Selector 1 is the same compare with both operands treated as unsigned.
- R4: Selector 2 is a signed compare of `opa_i` against zero, with the code values of R2.
- R5: When `wide_i`=0, only bits 31:0 of each operand take part. Bit 31 is the sign, and the shift count is `shamt_i[4:0]`. When `wide_i`=1, all 64 bits take part, bit 63 is the sign, and the count is `shamt_i[5:0]`.
- R6: Selector 3 is test-under-mask, with `opa_i` as the value and `opb_i` as the mask. The code is 0 when value AND mask is zero, which includes an all-zero mask. It is 3 when every mask bit is set in the value.
- R7: For a mixed pattern under selector 3, the code is 1 in 32-bit mode. In 64-bit mode it is 2 if the value bit at the mask's highest set position is 1, and 1 otherwise.
- R8: Selector 4 is insert-under-mask, with `opa_i` as the value and `opb_i` as the mask. The code is 0 when value AND mask is zero. Otherwise it is 1 if the value bit at the mask's highest set position is 1, and 2 if that bit is 0.
- R9: Selector 5 grades an arithmetic left shift of `opa_i` by count k. The code is 3 when any of the top k bits of the source differs from the sign bit. A count of 0 never gives 3.
- R10: When selector 5 does not overflow, the result is formed from the sign bit and the low bits of source shifted left by k. The code is 0 if that result is zero, 1 if the sign is set, and 2 otherwise.
- R11: Selector 6 is the leading-one search. The code is 2 when `opa_i` is nonzero and 0 when it is zero.
- R12: Selector 7 is unused and always gives code 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation selector (encodings in R2 to R12) |
| wide_i | input | 1 | 1 selects 64-bit view, 0 selects 32-bit view |
| opa_i | input | 64 | First operand, value or shift source |
| opb_i | input | 64 | Second operand or mask |
| shamt_i | input | 6 | Shift count for selector 5 |
| cc_o | output | 2 | Registered condition code |

## Verification
Every code is due exactly one rising edge after its inputs are applied, because the only register on the path is the output flop. The bench drives each stimulus at a falling edge. It then waits for one rising edge and compares `cc_o` with a behavioural model at the next falling edge, before it applies the next stimulus. This gives one compare on every clock. The reset check samples in the same way while `rst` is held high with inputs that would otherwise give a nonzero code.

// File: rtl/cmpcc_pkg.sv
package cmpcc_pkg;

    typedef logic [1:0] cc_t;

    typedef enum logic [2:0] {
        OP_CMP_S     = 3'd0,
        OP_CMP_U     = 3'd1,
        OP_CMP_Z     = 3'd2,
        OP_TEST_MASK = 3'd3,
        OP_INS_MASK  = 3'd4,
        OP_SHL_ARITH = 3'd5,
        OP_LEAD_ONE  = 3'd6,
        OP_RSVD      = 3'd7
    } op_e;

    localparam cc_t CC_ZERO = 2'd0;
    localparam cc_t CC_LOW  = 2'd1;
    localparam cc_t CC_HIGH = 2'd2;
    localparam cc_t CC_OVF  = 2'd3;

    // Three-way grading shared by the compare and shift paths
    function automatic cc_t cc_from_sign(input logic is_zero, input logic is_neg);
        if (is_zero)      return CC_ZERO;
        else if (is_neg)  return CC_LOW;
        else              return CC_HIGH;
    endfunction

endpackage

// File: rtl/cmpcc_compare.sv
module cmpcc_compare
    import cmpcc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              wide_i,
    input  logic              signed_i,
    input  logic              vs_zero_i,
    output cc_t               cc_o
);
    localparam int EXT_W = DATA_W + 1;
    localparam int PAD_W = DATA_W - HALF_W + 1;

    logic [EXT_W-1:0] ext_a, ext_b;
    logic [DATA_W-1:0] b_eff;
    logic ext_sign_a, ext_sign_b;

    always_comb begin
        b_eff = vs_zero_i ? '0 : b_i;
        ext_sign_a = signed_i & (wide_i ? a_i[DATA_W-1] : a_i[HALF_W-1]);
        ext_sign_b = signed_i & (wide_i ? b_eff[DATA_W-1] : b_eff[HALF_W-1]);
        if (wide_i) begin
            ext_a = {ext_sign_a, a_i};
            ext_b = {ext_sign_b, b_eff};
        end else begin
            ext_a = {{PAD_W{ext_sign_a}}, a_i[HALF_W-1:0]};
            ext_b = {{PAD_W{ext_sign_b}}, b_eff[HALF_W-1:0]};
        end
        cc_o = cc_from_sign(ext_a == ext_b, $signed(ext_a) < $signed(ext_b));
    end
endmodule

// File: rtl/cmpcc_masktest.sv
module cmpcc_masktest
    import cmpcc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              wide_i,
    output cc_t               tm_cc_o,
    output cc_t               ins_cc_o
);
    localparam int PAD_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] v, m, hit;
    logic lead_bit;

    always_comb begin
        v = wide_i ? val_i  : {{PAD_W{1'b0}}, val_i[HALF_W-1:0]};
        m = wide_i ? mask_i : {{PAD_W{1'b0}}, mask_i[HALF_W-1:0]};
        hit = v & m;
    end

    // Priority pick: value bit under the highest set mask bit
    always_comb begin
        lead_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (m[i]) lead_bit = v[i];
        end
    end

    always_comb begin
        if (hit == '0)        tm_cc_o = CC_ZERO;
        else if (hit == m)    tm_cc_o = CC_OVF;
        else if (!wide_i)     tm_cc_o = CC_LOW;
        else                  tm_cc_o = lead_bit ? CC_HIGH : CC_LOW;

        if (hit == '0)        ins_cc_o = CC_ZERO;
        else                  ins_cc_o = lead_bit ? CC_LOW : CC_HIGH;
    end
endmodule

// File: rtl/cmpcc_shlovf.sv
module cmpcc_shlovf
    import cmpcc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32,
    localparam int CNT_W  = $clog2(DATA_W),
    localparam int HCNT_W = $clog2(HALF_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [CNT_W-1:0]  shamt_i,
    input  logic              wide_i,
    output cc_t               cc_o
);
    localparam int PAD_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] just, shifted, res;
    logic [CNT_W-1:0]  k;
    logic sign, ovf;

    // Left-justify the 32-bit view so one sign position serves both widths
    always_comb begin
        just = wide_i ? src_i : {src_i[HALF_W-1:0], {PAD_W{1'b0}}};
        k    = wide_i ? shamt_i : {{(CNT_W-HCNT_W){1'b0}}, shamt_i[HCNT_W-1:0]};
        sign = just[DATA_W-1];
    end

    // Top-k window built by index compare: k=0 selects nothing
    always_comb begin
        ovf = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= DATA_W - int'(k) && just[i] != sign) ovf = 1'b1;
        end
    end

    always_comb begin
        shifted = just << k;
        res     = {sign, shifted[DATA_W-2:0]};
        cc_o    = ovf ? CC_OVF : cc_from_sign(res == '0, sign);
    end
endmodule

// File: rtl/cmpcc_unit.sv
module cmpcc_unit
    import cmpcc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [CNT_W-1:0]  shamt_i,
    output logic [1:0]        cc_o
);
    op_e op;
    cc_t cmp_cc, tm_cc, ins_cc, shl_cc, next_cc;
    logic lead_nz;

    assign op = op_e'(op_i);

    cmpcc_compare #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cmp (
        .a_i       (opa_i),
        .b_i       (opb_i),
        .wide_i    (wide_i),
        .signed_i  (op != OP_CMP_U),
        .vs_zero_i (op == OP_CMP_Z),
        .cc_o      (cmp_cc)
    );

    cmpcc_masktest #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mask (
        .val_i    (opa_i),
        .mask_i   (opb_i),
        .wide_i   (wide_i),
        .tm_cc_o  (tm_cc),
        .ins_cc_o (ins_cc)
    );

    cmpcc_shlovf #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_shl (
        .src_i   (opa_i),
        .shamt_i (shamt_i),
        .wide_i  (wide_i),
        .cc_o    (shl_cc)
    );

    assign lead_nz = wide_i ? (|opa_i) : (|opa_i[HALF_W-1:0]);

    always_comb begin
        unique case (op)
            OP_CMP_S, OP_CMP_U, OP_CMP_Z: next_cc = cmp_cc;
            OP_TEST_MASK:                 next_cc = tm_cc;
            OP_INS_MASK:                  next_cc = ins_cc;
            OP_SHL_ARITH:                 next_cc = shl_cc;
            OP_LEAD_ONE:                  next_cc = lead_nz ? CC_HIGH : CC_ZERO;
            default:                      next_cc = CC_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cc_o <= CC_ZERO;
        else     cc_o <= next_cc;
    end

    AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && (op_i == 3'd0 || op_i == 3'd1) && opa_i == opb_i) |-> cc_o == 2'd0); // R2
    AST_CMP_NEVER_OVF: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i <= 3'd2) |-> cc_o != 2'd3); // R3
    AST_TM_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd3 && (opa_i & opb_i) == '0) |-> cc_o == 2'd0); // R6
    AST_TM_NARROW_MIXED: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd3 && !wide_i) |-> cc_o != 2'd2); // R7
    AST_INS_NEVER_OVF: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd4) |-> cc_o != 2'd3); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd5 && shamt_i == '0) |-> cc_o != 2'd3); // R9
    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd6 && opa_i == '0) |-> cc_o == 2'd0); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_i == 3'd7) |-> cc_o == 2'd0); // R12
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> cc_o == 2'd0); // R1
endmodule

// File: tb/cmpcc_unit_tb.sv
module cmpcc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b1;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [5:0]  shamt_i = '0;
    logic [1:0]  cc_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmpcc_unit dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i),
        .opa_i(opa_i), .opb_i(opb_i), .shamt_i(shamt_i), .cc_o(cc_o)
    );

    function automatic logic [1:0] ref_cc(input logic [2:0] op, input logic wd,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [5:0] sh);
        longint sa, sb;
        logic [63:0] va, vb, r, shres;
        int w, k, top;
        logic sgn, hb;
        w  = wd ? 64 : 32;
        va = wd ? a : {32'd0, a[31:0]};
        vb = wd ? b : {32'd0, b[31:0]};
        sa = wd ? longint'(a) : longint'(int'(a[31:0]));
        sb = wd ? longint'(b) : longint'(int'(b[31:0]));
        case (op)
            3'd0: return (sa == sb) ? 2'd0 : (sa < sb) ? 2'd1 : 2'd2;
            3'd1: return (va == vb) ? 2'd0 : (va < vb) ? 2'd1 : 2'd2;
            3'd2: return (sa == 0) ? 2'd0 : (sa < 0) ? 2'd1 : 2'd2;
            3'd3, 3'd4: begin
                r = va & vb;
                top = -1;
                for (int j = 63; j >= 0; j--) if (top < 0 && vb[j]) top = j;
                hb = (top >= 0) ? va[top] : 1'b0;
                if (r == 0) return 2'd0;
                if (op == 3'd4) return hb ? 2'd1 : 2'd2;
                if (r == vb) return 2'd3;
                if (!wd) return 2'd1;
                return hb ? 2'd2 : 2'd1;
            end
            3'd5: begin
                k = wd ? int'(sh) : int'(sh[4:0]);
                sgn = va[w-1];
                for (int j = 0; j < k; j++) if (va[w-1-j] != sgn) return 2'd3;
                shres = va << k;
                if (!wd) shres = shres & 64'h0000_0000_FFFF_FFFF;
                shres[w-1] = sgn;
                if (shres == 0) return 2'd0;
                return sgn ? 2'd1 : 2'd2;
            end
            3'd6: return (va != 0) ? 2'd2 : 2'd0;
            default: return 2'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6/R7";
            3'd4: return "R8";
            3'd5: return "R9/R10";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cc actual=%0d expected=%0d (op=%0d wide=%0b a=%h b=%h sh=%0d)",
                     tag, act, exp, op_i, wide_i, opa_i, opb_i, shamt_i);
        end
    endtask

    // Drive at a falling edge, result due at the next rising edge, sample at the falling edge after it
    task automatic apply(input logic [2:0] op, input logic wd, input logic [63:0] a,
                         input logic [63:0] b, input logic [5:0] sh, input string tag);
        logic [1:0] exp;
        op_i = op; wide_i = wd; opa_i = a; opb_i = b; shamt_i = sh;
        exp = ref_cc(op, wd, a, b, sh);
        @(posedge clk);
        @(negedge clk);
        check(tag, cc_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the code at 0 even with a nonzero-producing stimulus
        op_i = 3'd6; wide_i = 1'b1; opa_i = 64'h1;
        repeat (3) @(negedge clk);
        check("R1", cc_o, 2'd0);
        rst = 1'b0;
        apply(3'd6, 1'b1, 64'h1, 64'h0, 6'd0, "R1");
        // R2 signed compare
        apply(3'd0, 1'b1, 64'd7, 64'd7, 6'd0, "R2");
        apply(3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 6'd0, "R2");
        apply(3'd0, 1'b1, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, "R2");
        // R3 unsigned compare differs from signed
        apply(3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 6'd0, "R3");
        apply(3'd1, 1'b1, 64'd2, 64'd3, 6'd0, "R3");
        // R4 against zero
        apply(3'd2, 1'b1, 64'h8000_0000_0000_0000, 64'd5, 6'd0, "R4");
        apply(3'd2, 1'b1, 64'd0, 64'd5, 6'd0, "R4");
        apply(3'd2, 1'b1, 64'd4, 64'hFFFF, 6'd0, "R4");
        // R5 narrow view
        apply(3'd0, 1'b0, 64'hFFFF_FFFF_0000_0005, 64'd5, 6'd0, "R5");
        apply(3'd2, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 6'd0, "R5");
        apply(3'd1, 1'b0, 64'h0000_0001_0000_0000, 64'd1, 6'd0, "R5");
        // R6 / R7 test under mask
        apply(3'd3, 1'b1, 64'hFFFF, 64'h0, 6'd0, "R6");
        apply(3'd3, 1'b1, 64'hF0F0, 64'hF000, 6'd0, "R6");
        apply(3'd3, 1'b0, 64'h0100, 64'h0300, 6'd0, "R7");
        apply(3'd3, 1'b1, 64'h0200, 64'h0300, 6'd0, "R7");
        apply(3'd3, 1'b1, 64'h0100, 64'h0300, 6'd0, "R7");
        // R8 insert under mask
        apply(3'd4, 1'b1, 64'h0, 64'hFF, 6'd0, "R8");
        apply(3'd4, 1'b1, 64'h80, 64'hFF, 6'd0, "R8");
        apply(3'd4, 1'b1, 64'h01, 64'hFF, 6'd0, "R8");
        // R9 / R10 arithmetic left shift
        apply(3'd5, 1'b1, 64'h4000_0000_0000_0000, 64'd0, 6'd2, "R9");
        apply(3'd5, 1'b1, 64'hC000_0000_0000_0000, 64'd0, 6'd0, "R9");
        apply(3'd5, 1'b0, 64'h0000_0000_4000_0000, 64'd0, 6'd34, "R9");
        apply(3'd5, 1'b1, 64'h4000_0000_0000_0000, 64'd0, 6'd1, "R10");
        apply(3'd5, 1'b1, 64'h0000_0000_0000_0003, 64'd0, 6'd4, "R10");
        apply(3'd5, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'd0, 6'd3, "R10");
        // R11 leading one
        apply(3'd6, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0, "R11");
        apply(3'd6, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0, "R11");
        // R12 reserved selector
        apply(3'd7, 1'b1, 64'hFFFF, 64'hFFFF, 6'd5, "R12");
        // Mixed random patterns, compared every clock
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            logic [63:0] a, b;
            op = 3'($urandom_range(0, 7));
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) b = a;
            if ($urandom_range(0, 3) == 0) a = a & {$urandom, $urandom};
            if ($urandom_range(0, 4) == 0) a = {64{a[63]}} ^ (a >> $urandom_range(0, 63));
            apply(op, 1'($urandom_range(0, 1)), a, b, 6'($urandom_range(0, 63)), tag_of(op));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule